// File: doc/BRIEF.md
# Vector Register Block Allocator

This block hands out the vector register space of one SIMD to waves. A request names a wave slot, the number of registers each thread needs, the wave width (32 or 64 lanes) and the block granularity (16 or 32 registers). The block rounds the count up to whole blocks and converts it into capacity units. It then searches a free bitmap for the lowest contiguous run that fits. The answer is one of three: grant with a base unit index, stall when no run fits, or reject when the request is illegal.

A retiring wave returns its space with a release naming its slot. The block frees exactly the units it recorded for that slot at grant time. It keeps a count of resident waves.

Capacity is counted in units of 16 registers × 32 lanes × 4 bytes. That gives 96 units for a 192 KB file. A request and a release in the same cycle are handled release first, so the freed space is visible to that cycle's request.

Top module: `reg_block_alloc`

## Requirements
- R1: The block count is ceil(regs / B). B is 16 when `alloc_blk32_i`=0 and 32 when it is 1; for example 97 registers gives 7 blocks or 4 blocks.
- R2: Units = blocks × (2 if B=32, else 1) × (2 if `alloc_wave64_i`=1, else 1). A grant reports this value on `resp_units_o`.
- R3: A request is rejected (`resp_code_o`=2) when regs is 0, when regs is above 256, or when it needs more than 8 blocks. Such a request changes no state.
- R4: A request whose slot already holds a wave is rejected (`resp_code_o`=2).
- R5: A legal request is granted (`resp_code_o`=0) at the lowest base unit index whose contiguous run of free units fits it. Those units become used.
- R6: A legal request for which no contiguous run fits gets stall (`resp_code_o`=1). It changes no state.
- R7: A release of an occupied slot frees exactly the units granted to that slot. The slot may then be allocated again.
- R8: A release of an empty slot changes nothing. `rel_err_o` is high for exactly the cycle after it.
- R9: When a release and a request arrive in the same cycle, the release is applied first. Its units and its slot are available to that request.
- R10: `resident_o` equals the number of occupied slots, at most 16.
- R11: After reset all units are free, `resident_o` is 0, `resp_valid_o` and `rel_err_o` are low, and both ready outputs are high.
- R12: Every accepted request yields exactly one response, with `resp_valid_o` high in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request valid |
| alloc_ready_o | output | 1 | Allocation request accepted |
| alloc_slot_i | input | 4 | Wave slot of the request |
| alloc_regs_i | input | 10 | Registers per thread requested |
| alloc_wave64_i | input | 1 | 1: 64-lane wave, 0: 32-lane wave |
| alloc_blk32_i | input | 1 | 1: 32-register blocks, 0: 16-register blocks |
| rel_valid_i | input | 1 | Release request valid |
| rel_ready_o | output | 1 | Release accepted |
| rel_slot_i | input | 4 | Wave slot being released |
| resp_valid_o | output | 1 | Response valid |
| resp_code_o | output | 2 | 0 grant, 1 stall, 2 reject |
| resp_base_o | output | 7 | Base unit index of a grant |
| resp_units_o | output | 6 | Units occupied by a grant |
| rel_err_o | output | 1 | Release named an empty slot |
| resident_o | output | 5 | Number of resident waves |

## Verification
The bench builds the block with its default values: 96 units, 16 slots, a 256-register limit and 8 blocks per wave. With these values a single 256-register, 64-lane, 32-register-block wave takes a third of the file. Three such waves fill it exactly, so exact fit, stall on a full file and reuse of holes can be reached in a few requests. Sixteen slots is small enough to fill every slot and hit the residency limit in one loop.

// File: rtl/rba_pkg.sv
package rba_pkg;
  typedef enum logic [1:0] {
    RESP_GRANT  = 2'd0,
    RESP_STALL  = 2'd1,
    RESP_REJECT = 2'd2
  } resp_code_e;
endpackage

// File: rtl/rba_sizer.sv
module rba_sizer #(
  parameter int MAX_REGS  = 256,
  parameter int MAX_BLKS  = 8,
  parameter int BASE_REGS = 16,
  parameter int REG_W     = $clog2(MAX_REGS) + 2,
  parameter int LEN_W     = $clog2(MAX_BLKS * 4 + 1)
) (
  input  logic [REG_W-1:0] regs_i,
  input  logic             blk32_i,
  input  logic             wave64_i,
  output logic             legal_o,
  output logic [LEN_W-1:0] units_o
);
  localparam int SH = $clog2(BASE_REGS);

  logic [REG_W:0] rounded;
  logic [REG_W:0] blocks;
  logic [REG_W+2:0] units_wide;

  always_comb begin
    if (blk32_i) begin
      rounded = {1'b0, regs_i} + (REG_W+1)'(2 * BASE_REGS - 1);
      blocks  = rounded >> (SH + 1);
    end else begin
      rounded = {1'b0, regs_i} + (REG_W+1)'(BASE_REGS - 1);
      blocks  = rounded >> SH;
    end
    units_wide = {2'b00, blocks} << ({1'b0, blk32_i} + {1'b0, wave64_i});
    legal_o = (regs_i != '0) && (32'(regs_i) <= MAX_REGS) && (32'(blocks) <= MAX_BLKS);
    units_o = legal_o ? units_wide[LEN_W-1:0] : '0;
  end
endmodule

// File: rtl/rba_first_fit.sv
module rba_first_fit #(
  parameter int UNITS  = 96,
  parameter int LEN_W  = 6,
  parameter int BASE_W = $clog2(UNITS)
) (
  input  logic [UNITS-1:0]  free_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              found_o,
  output logic [BASE_W-1:0] base_o
);
  localparam int RUN_W = $clog2(UNITS + 1);

  logic [RUN_W-1:0] run [UNITS+1];
  logic [UNITS-1:0] fit;

  assign run[UNITS] = '0;

  // free-run length starting at each unit, built from the top down
  for (genvar i = 0; i < UNITS; i++) begin : g_run
    assign run[i] = free_i[i] ? run[i+1] + RUN_W'(1) : '0;
    assign fit[i] = (len_i != '0) && (32'(run[i]) >= 32'(len_i));
  end

  always_comb begin
    found_o = 1'b0;
    base_o  = '0;
    for (int i = UNITS - 1; i >= 0; i--) begin
      if (fit[i]) begin
        found_o = 1'b1;
        base_o  = BASE_W'(i);
      end
    end
  end
endmodule

// File: rtl/rba_slot_table.sv
module rba_slot_table #(
  parameter int SLOTS  = 16,
  parameter int BASE_W = 7,
  parameter int LEN_W  = 6,
  parameter int SLOT_W = $clog2(SLOTS),
  parameter int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [SLOT_W-1:0] set_slot_i,
  input  logic [BASE_W-1:0] set_base_i,
  input  logic [LEN_W-1:0]  set_units_i,
  input  logic              clr_i,
  input  logic [SLOT_W-1:0] clr_slot_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [SLOTS-1:0]  occ_o,
  output logic [BASE_W-1:0] rd_base_o,
  output logic [LEN_W-1:0]  rd_units_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [BASE_W-1:0] base_q  [SLOTS];
  logic [LEN_W-1:0]  units_q [SLOTS];
  logic [SLOTS-1:0]  occ_q;
  logic [CNT_W-1:0]  cnt_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic set_here, clr_here;
    assign set_here = set_i && (set_slot_i == SLOT_W'(s));
    assign clr_here = clr_i && (clr_slot_i == SLOT_W'(s));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        occ_q[s]   <= 1'b0;
        base_q[s]  <= '0;
        units_q[s] <= '0;
      end else if (set_here) begin
        occ_q[s]   <= 1'b1;
        base_q[s]  <= set_base_i;
        units_q[s] <= set_units_i;
      end else if (clr_here) begin
        occ_q[s]   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(set_i) - CNT_W'(clr_i);
  end

  assign occ_o      = occ_q;
  assign rd_base_o  = base_q[rd_slot_i];
  assign rd_units_o = units_q[rd_slot_i];
  assign count_o    = cnt_q;

  p_count_match_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) == $countones(occ_q));
  p_count_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= SLOTS);
endmodule

// File: rtl/reg_block_alloc.sv
module reg_block_alloc
  import rba_pkg::*;
#(
  parameter int UNITS     = 96,
  parameter int SLOTS     = 16,
  parameter int MAX_REGS  = 256,
  parameter int MAX_BLKS  = 8,
  parameter int BASE_REGS = 16,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int REG_W    = $clog2(MAX_REGS) + 2,
  localparam int BASE_W   = $clog2(UNITS),
  localparam int LEN_W    = $clog2(MAX_BLKS * 4 + 1),
  localparam int CNT_W    = $clog2(SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  output logic              alloc_ready_o,
  input  logic [SLOT_W-1:0] alloc_slot_i,
  input  logic [REG_W-1:0]  alloc_regs_i,
  input  logic              alloc_wave64_i,
  input  logic              alloc_blk32_i,
  input  logic              rel_valid_i,
  output logic              rel_ready_o,
  input  logic [SLOT_W-1:0] rel_slot_i,
  output logic              resp_valid_o,
  output logic [1:0]        resp_code_o,
  output logic [BASE_W-1:0] resp_base_o,
  output logic [LEN_W-1:0]  resp_units_o,
  output logic              rel_err_o,
  output logic [CNT_W-1:0]  resident_o
);
  function automatic logic [UNITS-1:0] span(input logic [BASE_W-1:0] b,
                                            input logic [LEN_W-1:0] n);
    logic [UNITS-1:0] m;
    for (int i = 0; i < UNITS; i++)
      m[i] = (i >= int'(b)) && (i < int'(b) + int'(n));
    return m;
  endfunction

  logic [UNITS-1:0]  used_q, used_d, rel_mask, grant_mask, free_eff;
  logic [SLOTS-1:0]  occ, occ_eff;
  logic [BASE_W-1:0] rel_base, fit_base;
  logic [LEN_W-1:0]  rel_units, req_units;
  logic              rel_hit, rel_miss, req_legal, fit_found, slot_busy, do_grant;
  resp_code_e        code_d;

  assign alloc_ready_o = 1'b1;
  assign rel_ready_o   = 1'b1;

  rba_slot_table #(
    .SLOTS (SLOTS), .BASE_W(BASE_W), .LEN_W(LEN_W)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (do_grant),
    .set_slot_i (alloc_slot_i),
    .set_base_i (fit_base),
    .set_units_i(req_units),
    .clr_i      (rel_hit),
    .clr_slot_i (rel_slot_i),
    .rd_slot_i  (rel_slot_i),
    .occ_o      (occ),
    .rd_base_o  (rel_base),
    .rd_units_o (rel_units),
    .count_o    (resident_o)
  );

  rba_sizer #(
    .MAX_REGS(MAX_REGS), .MAX_BLKS(MAX_BLKS), .BASE_REGS(BASE_REGS)
  ) u_sizer (
    .regs_i  (alloc_regs_i),
    .blk32_i (alloc_blk32_i),
    .wave64_i(alloc_wave64_i),
    .legal_o (req_legal),
    .units_o (req_units)
  );

  // release is applied before the same-cycle request is judged
  assign rel_hit  = rel_valid_i && occ[rel_slot_i];
  assign rel_miss = rel_valid_i && !occ[rel_slot_i];
  assign rel_mask = rel_hit ? span(rel_base, rel_units) : '0;
  assign free_eff = ~(used_q & ~rel_mask);
  assign occ_eff  = occ & ~(rel_hit ? (SLOTS'(1) << rel_slot_i) : '0);

  rba_first_fit #(
    .UNITS(UNITS), .LEN_W(LEN_W)
  ) u_fit (
    .free_i (free_eff),
    .len_i  (req_units),
    .found_o(fit_found),
    .base_o (fit_base)
  );

  always_comb begin
    slot_busy  = occ_eff[alloc_slot_i];
    if (!req_legal || slot_busy) code_d = RESP_REJECT;
    else if (fit_found)          code_d = RESP_GRANT;
    else                         code_d = RESP_STALL;
    do_grant   = alloc_valid_i && (code_d == RESP_GRANT);
    grant_mask = do_grant ? span(fit_base, req_units) : '0;
    used_d     = (used_q & ~rel_mask) | grant_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q       <= '0;
      resp_valid_o <= 1'b0;
      resp_code_o  <= '0;
      resp_base_o  <= '0;
      resp_units_o <= '0;
      rel_err_o    <= 1'b0;
    end else begin
      used_q       <= used_d;
      resp_valid_o <= alloc_valid_i;
      rel_err_o    <= rel_miss;
      if (alloc_valid_i) begin
        resp_code_o  <= code_d;
        resp_base_o  <= (code_d == RESP_GRANT) ? fit_base : '0;
        resp_units_o <= req_units;
      end
    end
  end

  p_resp_follows_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_valid_i |=> resp_valid_o);
  p_reject_oversize_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && 32'(alloc_regs_i) > MAX_REGS) |=> (resp_code_o == RESP_REJECT));
  p_grant_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_code_o == RESP_GRANT) |->
      (resp_units_o != '0 && 32'(resp_base_o) + 32'(resp_units_o) <= UNITS));
  p_grant_marked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_code_o == RESP_GRANT) |->
      ((used_q & span(resp_base_o, resp_units_o)) == span(resp_base_o, resp_units_o)));
  p_stall_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_code_o == RESP_STALL && !$past(rel_valid_i)) |->
      (used_q == $past(used_q)));
  p_err_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_err_o |-> $past(rel_valid_i));
endmodule

// File: tb/reg_block_alloc_tb_top.sv
module reg_block_alloc_tb_top;
  localparam int UNITS = 96;
  localparam int SLOTS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_valid = 1'b0, alloc_wave64 = 1'b0, alloc_blk32 = 1'b0;
  logic [3:0] alloc_slot = '0, rel_slot = '0;
  logic [9:0] alloc_regs = '0;
  logic       rel_valid = 1'b0;
  logic       alloc_ready, rel_ready, resp_valid, rel_err;
  logic [1:0] resp_code;
  logic [6:0] resp_base;
  logic [5:0] resp_units;
  logic [4:0] resident;

  always #10 clk = ~clk;

  reg_block_alloc dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_ready_o(alloc_ready),
    .alloc_slot_i(alloc_slot), .alloc_regs_i(alloc_regs),
    .alloc_wave64_i(alloc_wave64), .alloc_blk32_i(alloc_blk32),
    .rel_valid_i(rel_valid), .rel_ready_o(rel_ready), .rel_slot_i(rel_slot),
    .resp_valid_o(resp_valid), .resp_code_o(resp_code),
    .resp_base_o(resp_base), .resp_units_o(resp_units),
    .rel_err_o(rel_err), .resident_o(resident)
  );

  typedef struct {int code; int base; int units; string req;} exp_item_t;
  exp_item_t sb_q[$];

  int checks = 0, failures = 0;
  bit done = 0;
  bit m_used [UNITS];
  bit m_occ [SLOTS];
  int m_base [SLOTS];
  int m_units [SLOTS];
  int m_res = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit model_release(int s);
    if (!m_occ[s]) return 1'b0;
    for (int i = m_base[s]; i < m_base[s] + m_units[s]; i++) m_used[i] = 1'b0;
    m_occ[s] = 1'b0;
    m_res--;
    return 1'b1;
  endfunction

  function automatic exp_item_t model_alloc(int s, int regs, bit w64, bit b32, string req);
    exp_item_t e;
    int blk, blocks, units;
    e.req = req; e.base = 0; e.units = 0;
    blk = b32 ? 32 : 16;
    blocks = (regs + blk - 1) / blk;
    if (regs == 0 || regs > 256 || blocks > 8 || m_occ[s]) begin
      e.code = 2;
      return e;
    end
    units = blocks * (b32 ? 2 : 1) * (w64 ? 2 : 1);
    e.units = units;
    e.code = 1;
    for (int b = 0; b + units <= UNITS; b++) begin
      bit ok = 1'b1;
      for (int k = b; k < b + units; k++) if (m_used[k]) ok = 1'b0;
      if (ok) begin
        e.code = 0; e.base = b;
        for (int k = b; k < b + units; k++) m_used[k] = 1'b1;
        m_occ[s] = 1'b1; m_base[s] = b; m_units[s] = units; m_res++;
        return e;
      end
    end
    return e;
  endfunction

  task automatic op(bit do_a, int s, int regs, bit w64, bit b32,
                    bit do_r, int rs, string req);
    bit exp_err;
    @(negedge clk);
    exp_err = 1'b0;
    if (do_r) begin
      rel_valid = 1'b1; rel_slot = 4'(rs);
      exp_err = !model_release(rs);
    end
    if (do_a) begin
      alloc_valid = 1'b1; alloc_slot = 4'(s); alloc_regs = 10'(regs);
      alloc_wave64 = w64; alloc_blk32 = b32;
      sb_q.push_back(model_alloc(s, regs, w64, b32, req));
    end
    @(negedge clk);
    alloc_valid = 1'b0; rel_valid = 1'b0;
    if (do_r) check(rel_err == exp_err, "R8", "rel_err", int'(rel_err), int'(exp_err));
    check(int'(resident) == m_res, "R10", "resident", int'(resident), m_res);
  endtask

  // monitor: pop one expectation per response
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R12", "unexpected response", 1, 0);
      end else begin
        exp_item_t e;
        e = sb_q.pop_front();
        check(int'(resp_code) == e.code, e.req, "code", int'(resp_code), e.code);
        if (e.code == 0) begin
          check(int'(resp_base) == e.base, e.req, "base", int'(resp_base), e.base);
          check(int'(resp_units) == e.units, "R2", "units", int'(resp_units), e.units);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R12", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(resident == 0, "R11", "resident", int'(resident), 0);
    check(resp_valid == 0, "R11", "resp_valid", int'(resp_valid), 0);
    check(rel_err == 0, "R11", "rel_err", int'(rel_err), 0);
    check(alloc_ready && rel_ready, "R11", "ready", int'(alloc_ready && rel_ready), 1);

    op(1, 0, 97, 0, 0, 0, 0, "R1");   // 7 blocks -> 7 units at 0
    op(1, 1, 97, 0, 1, 0, 0, "R1");   // 4 blocks -> 8 units at 7
    op(1, 2, 64, 1, 0, 0, 0, "R2");   // 4 blocks x2 -> 8 units at 15
    op(1, 3, 256, 1, 1, 0, 0, "R2");  // 8 x2 x2 -> 32 units at 23
    op(1, 4, 300, 0, 1, 0, 0, "R3");
    op(1, 4, 0, 0, 0, 0, 0, "R3");
    op(1, 4, 129, 0, 0, 0, 0, "R3");  // 9 blocks of 16
    op(1, 0, 16, 0, 0, 0, 0, "R4");
    op(1, 4, 256, 1, 1, 0, 0, "R5");  // 32 units at 55
    op(1, 5, 200, 0, 1, 0, 0, "R6");  // 14 units, only 9 left
    op(0, 0, 0, 0, 0, 1, 1, "R7");    // free 7..14
    op(1, 5, 64, 0, 1, 0, 0, "R7");   // 4 units into the hole at 7
    op(0, 0, 0, 0, 0, 1, 9, "R8");    // empty slot
    op(1, 6, 256, 1, 1, 1, 3, "R9");  // needs the space freed that cycle
    op(1, 3, 16, 0, 0, 1, 6, "R9");   // slot freed and reused together
    for (int s = 7; s < SLOTS; s++) op(1, s, 16, 0, 0, 0, 0, "R10");
    op(1, 1, 16, 0, 0, 0, 0, "R10");
    op(1, 6, 16, 0, 0, 0, 0, "R10");
    check(resident == 5'd16, "R10", "full resident", int'(resident), 16);
    op(1, 9, 16, 0, 0, 0, 0, "R4");
    for (int s = 0; s < SLOTS; s++) op(0, 0, 0, 0, 0, 1, s, "R7");
    check(resident == 0, "R10", "empty resident", int'(resident), 0);
    op(1, 0, 256, 1, 1, 0, 0, "R5");
    op(1, 1, 256, 1, 1, 0, 0, "R5");
    op(1, 2, 256, 1, 1, 0, 0, "R5");  // exact fill 64..95
    op(1, 3, 1, 0, 0, 0, 0, "R6");    // full file
    op(0, 0, 0, 0, 0, 1, 1, "R7");
    op(1, 3, 32, 1, 0, 0, 0, "R5");   // 4 units at 32
    op(1, 4, 255, 0, 1, 0, 0, "R1");  // 8 blocks of 32 -> 16 units at 36
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R12", "pending responses", sb_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule